// File: doc/BRIEF.md
# Streaming Radix-2 Number Theoretic Transform Pipeline

This block computes an n-point radix-2 number theoretic transform over the integers modulo the Fermat prime 65537. It accepts one 17-bit residue per clock and returns the n transformed residues as a serial stream after a fixed delay. The structure is a chain of log2(n) delay-feedback stages. Each stage holds a feedback delay line of n/2^(s+1) words, one modular butterfly, a stage-local twiddle table and an output multiplexer. Frames can follow each other with no idle cycles between them.

A frame is n consecutive samples. The first sample of a frame carries a start marker. Every stage realigns its position counter when that marker reaches it. A mode input selects forward twiddles (powers of ω) or inverse twiddles (powers of ω^-1) from the same tables. The inverse result is not scaled by n^-1, and the output order is bit-reversed. The root ω is derived from a generator parameter as GEN^(65536/n) mod 65537.

Top module: `ntt_sdf_pipe`

## Requirements
- R1: While reset is held, and on the first cycle after it, out_vld and out_sof are 0.
- R2: With inv_mode = 0, the sample at output position k of a frame (k = 0 is the one flagged by out_sof) equals X[r] = sum over i of x[i]·ω^(i·r) mod 65537, where r is the log2(n)-bit reversal of k.
- R3: With inv_mode = 1, output position k equals sum over i of x[i]·ω^(−i·r) mod 65537, with r the bit reversal of k and no division by n.
- R4: out_sof is high exactly L = n + log2(n) − 1 rising edges after the edge that samples in_sof high. For n = 16, L is 19.
- R5: out_vld repeats in_vld delayed by the same L edges. An input frame of n valid samples therefore yields exactly n valid outputs, with no extra or missing samples.
- R6: Frames presented back to back, with the next in_sof on the cycle after the previous frame's last sample, are each transformed correctly.
- R7: An in_sof that arrives in the middle of an unfinished frame restarts the frame position in every stage. The frame it starts is transformed correctly.
- R8: Every valid output is a reduced residue, strictly less than 65537.
- R9: Inputs at the top of the range (65536 = −1 mod p) transform correctly with no overflow in the butterfly or the modular multiply.
- R10: inv_mode must be held from a frame's in_sof until that frame's out_sof plus n cycles. The block places no other condition on it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| inv_mode | input | 1 | 0 selects forward twiddles, 1 selects inverse twiddles |
| in_vld | input | 1 | Input sample is valid |
| in_sof | input | 1 | Input sample is position 0 of a frame |
| in_dat | input | 17 | Input residue, 0 to 65536 |
| out_vld | output | 1 | Output sample is valid |
| out_sof | output | 1 | Output sample is position 0 of a frame |
| out_dat | output | 17 | Output residue, bit-reversed order |

## Verification
Suppose a stage counter drifts away from the frame marker, or a twiddle is fetched with the wrong exponent. Some outputs of the next frame then become wrong residues, typically half of a frame's samples or more. This shows up L cycles after that frame's start. The reference is a direct quadratic transform, so each such error is flagged on the exact sample. Faults in the valid or marker delay lines break the fixed L relation on the first frame after reset. A faulty modular reduction yields out-of-range or incorrect residues as soon as the all-(p−1) frame passes through.

// File: rtl/ntt_sdf_pkg.sv
package ntt_sdf_pkg;
  localparam int DW = 17;
  typedef logic [DW-1:0] coef_t;
  localparam logic [DW:0] P_W = 18'd65537;

  function automatic coef_t add_mod(input coef_t a, input coef_t b);
    logic [DW:0] s;
    s = {1'b0, a} + {1'b0, b};
    if (s >= P_W) s = s - P_W;
    return s[DW-1:0];
  endfunction

  function automatic coef_t sub_mod(input coef_t a, input coef_t b);
    logic [DW:0] t;
    if (a >= b) t = {1'b0, a} - {1'b0, b};
    else        t = {1'b0, a} + P_W - {1'b0, b};
    return t[DW-1:0];
  endfunction

  // 2^16 = -1 mod p: fold the high half twice, then one conditional subtract
  function automatic coef_t mul_mod(input coef_t a, input coef_t b);
    logic [2*DW-1:0] pr;
    logic [18:0]     r1;
    logic [17:0]     r2;
    pr = {{DW{1'b0}}, a} * {{DW{1'b0}}, b};
    r1 = {3'b000, pr[15:0]} + 19'd262148 - {1'b0, pr[33:16]};
    r2 = {2'b00, r1[15:0]} + P_W - {15'd0, r1[18:16]};
    if (r2 >= P_W) r2 = r2 - P_W;
    return r2[DW-1:0];
  endfunction

  function automatic longint pow_mod(input longint base, input longint ex);
    longint r, b, e;
    r = 1;
    b = base % 65537;
    e = ex;
    while (e > 0) begin
      if (e[0]) r = (r * b) % 65537;
      b = (b * b) % 65537;
      e = e >> 1;
    end
    return r;
  endfunction
endpackage

// File: rtl/ntt_twiddle_rom.sv
module ntt_twiddle_rom
  import ntt_sdf_pkg::*;
#(
  parameter int N     = 16,
  parameter int STAGE = 0,
  parameter int GEN   = 3
) (
  input  logic                 inv,
  input  logic [IW-1:0]        idx,
  output coef_t                tw
);
  localparam int D  = N >> (STAGE + 1);
  localparam int IW = (D > 1) ? $clog2(D) : 1;
  localparam longint OMEGA = pow_mod(GEN, 65536 / N);

  coef_t fwd_tab [D];
  coef_t inv_tab [D];

  for (genvar g = 0; g < D; g++) begin : g_ent
    localparam coef_t FWD = coef_t'(pow_mod(OMEGA, g << STAGE));
    localparam coef_t INV = coef_t'(pow_mod(OMEGA, N - (g << STAGE)));
    assign fwd_tab[g] = FWD;
    assign inv_tab[g] = INV;
  end

  if (D > 1) begin : g_sel
    assign tw = inv ? inv_tab[idx] : fwd_tab[idx];
  end else begin : g_one
    logic unused_idx;
    assign unused_idx = idx[0];
    assign tw = inv ? inv_tab[0] : fwd_tab[0];
  end
endmodule

// File: rtl/ntt_sdf_stage.sv
module ntt_sdf_stage
  import ntt_sdf_pkg::*;
#(
  parameter int N     = 16,
  parameter int STAGE = 0,
  parameter int GEN   = 3
) (
  input  logic  clk,
  input  logic  rst,
  input  logic  inv,
  input  logic  in_vld,
  input  logic  in_sof,
  input  coef_t in_dat,
  output logic  out_vld,
  output logic  out_sof,
  output coef_t out_dat
);
  localparam int D  = N >> (STAGE + 1);
  localparam int CW = $clog2(2 * D);
  localparam int IW = (D > 1) ? $clog2(D) : 1;

  logic [CW-1:0] cnt, idx;
  logic [IW-1:0] tw_idx;
  logic          half;
  coef_t         dly [D];
  coef_t         head, tw, wr_dat;
  logic [D-1:0]  vsr, ssr;

  assign idx  = in_sof ? '0 : cnt;
  assign half = idx[CW-1];
  assign head = dly[D-1];

  if (D > 1) begin : g_idx
    assign tw_idx = idx[IW-1:0];
  end else begin : g_idx0
    assign tw_idx = '0;
  end

  ntt_twiddle_rom #(.N(N), .STAGE(STAGE), .GEN(GEN)) rom_i (
    .inv (inv),
    .idx (tw_idx),
    .tw  (tw)
  );

  // second half: difference times twiddle goes back into the delay line
  assign wr_dat = half ? mul_mod(sub_mod(head, in_dat), tw) : in_dat;

  always_ff @(posedge clk) begin
    dly[0] <= wr_dat;
    for (int g = 1; g < D; g++) dly[g] <= dly[g-1];
    out_dat <= half ? add_mod(head, in_dat) : head;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt     <= '0;
      vsr     <= '0;
      ssr     <= '0;
      out_vld <= 1'b0;
      out_sof <= 1'b0;
    end else begin
      cnt    <= idx + CW'(1);
      vsr[0] <= in_vld;
      ssr[0] <= in_sof;
      for (int g = 1; g < D; g++) begin
        vsr[g] <= vsr[g-1];
        ssr[g] <= ssr[g-1];
      end
      out_vld <= vsr[D-1];
      out_sof <= ssr[D-1];
    end
  end
endmodule

// File: rtl/ntt_sdf_pipe.sv
module ntt_sdf_pipe
  import ntt_sdf_pkg::*;
#(
  parameter int N   = 16,
  parameter int GEN = 3
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        inv_mode,
  input  logic        in_vld,
  input  logic        in_sof,
  input  logic [16:0] in_dat,
  output logic        out_vld,
  output logic        out_sof,
  output logic [16:0] out_dat
);
  localparam int S = $clog2(N);

  logic  vld_c [S+1];
  logic  sof_c [S+1];
  coef_t dat_c [S+1];

  assign vld_c[0] = in_vld;
  assign sof_c[0] = in_sof;
  assign dat_c[0] = in_dat;

  for (genvar s = 0; s < S; s++) begin : g_stage
    ntt_sdf_stage #(.N(N), .STAGE(s), .GEN(GEN)) stage_i (
      .clk     (clk),
      .rst     (rst),
      .inv     (inv_mode),
      .in_vld  (vld_c[s]),
      .in_sof  (sof_c[s]),
      .in_dat  (dat_c[s]),
      .out_vld (vld_c[s+1]),
      .out_sof (sof_c[s+1]),
      .out_dat (dat_c[s+1])
    );
  end

  assign out_vld = vld_c[S];
  assign out_sof = sof_c[S];
  assign out_dat = dat_c[S];
endmodule

// File: rtl/ntt_sdf_pipe_chk.sv
module ntt_sdf_pipe_chk #(
  parameter int N = 16
) (
  input logic        clk,
  input logic        rst,
  input logic        in_vld,
  input logic        in_sof,
  input logic        out_vld,
  input logic        out_sof,
  input logic [16:0] out_dat
);
  localparam int L = N + $clog2(N) - 1;

  logic [L-1:0] vh, sh;

  always_ff @(posedge clk) begin
    if (rst) begin
      vh <= '0;
      sh <= '0;
    end else begin
      vh <= {vh[L-2:0], in_vld};
      sh <= {sh[L-2:0], in_sof};
    end
  end

  AST_SOF_LATENCY: assert property (@(posedge clk) disable iff (rst)
    out_sof == sh[L-1]); // R4
  AST_VALID_DELAY: assert property (@(posedge clk) disable iff (rst)
    out_vld == vh[L-1]); // R5
  AST_SOF_HAS_VALID: assert property (@(posedge clk) disable iff (rst)
    out_sof |-> out_vld); // R5
  AST_RESULT_RANGE: assert property (@(posedge clk) disable iff (rst)
    out_vld |-> (out_dat < 17'd65537)); // R8
endmodule

bind ntt_sdf_pipe ntt_sdf_pipe_chk #(.N(N)) chk_i (
  .clk     (clk),
  .rst     (rst),
  .in_vld  (in_vld),
  .in_sof  (in_sof),
  .out_vld (out_vld),
  .out_sof (out_sof),
  .out_dat (out_dat)
);

// File: tb/ntt_sdf_pipe_tb_top.sv
module ntt_sdf_pipe_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int N    = 16;
  localparam int LOGN = 4;
  localparam int LAT  = N + LOGN - 1;
  localparam longint P = 65537;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        inv_mode = 1'b0;
  logic        in_vld = 1'b0;
  logic        in_sof = 1'b0;
  logic [16:0] in_dat = '0;
  logic        out_vld, out_sof;
  logic [16:0] out_dat;

  int cyc = 0;
  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  longint exp_q[$];
  bit     care_q[$];
  string  tag_q[$];
  int     sof_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  ntt_sdf_pipe #(.N(N), .GEN(3)) dut_i (
    .clk(clk), .rst(rst), .inv_mode(inv_mode), .in_vld(in_vld),
    .in_sof(in_sof), .in_dat(in_dat), .out_vld(out_vld),
    .out_sof(out_sof), .out_dat(out_dat)
  );

  function automatic longint tb_pow(input longint b, input longint e);
    longint r = 1;
    for (longint i = 0; i < e; i++) r = (r * b) % P;
    return r;
  endfunction

  function automatic int brev(input int k);
    int r = 0;
    for (int b = 0; b < LOGN; b++) if (k[b]) r |= 1 << (LOGN - 1 - b);
    return r;
  endfunction

  function automatic longint gen_x(input int kind, input int i);
    case (kind)
      0: return (i == 0) ? 1 : 0;
      1: return (longint'(i) * 4099 + 7) % P;
      2: return 12345;
      3: return 65536;
      default: return (longint'(i) * i * 31 + 65000) % P;
    endcase
  endfunction

  // driver: pushes the expected frame into the scoreboard, then drives it
  task automatic send_frame(input int len, input int kind, input bit md, input string tag);
    longint x [N];
    longint w, acc;
    w = tb_pow(tb_pow(3, 65536 / N), md ? N - 1 : 1);
    for (int i = 0; i < N; i++) x[i] = gen_x(kind, i);
    for (int k = 0; k < len; k++) begin
      acc = 0;
      if (len == N)
        for (int i = 0; i < N; i++)
          acc = (acc + x[i] * tb_pow(w, (i * brev(k)) % N)) % P;
      exp_q.push_back(acc);
      care_q.push_back(len == N);
      tag_q.push_back(tag);
    end
    for (int i = 0; i < len; i++) begin
      @(posedge clk); #1;
      inv_mode = md;
      in_vld   = 1'b1;
      in_sof   = (i == 0);
      in_dat   = 17'(x[i]);
      if (i == 0) sof_q.push_back(cyc);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1;
      in_vld = 1'b0; in_sof = 1'b0; in_dat = '0;
    end
  endtask

  // monitor
  always @(negedge clk) begin
    if (!rst && !done) begin
      if (out_vld) begin
        checks++;
        if (out_dat >= 17'd65537) begin
          fails++; $display("FAIL R8 residue out of range: got %0d expected < 65537", out_dat);
        end
        if (exp_q.size() == 0) begin
          checks++; fails++;
          $display("FAIL R5 extra valid output: got %0d expected none", out_dat);
        end else begin
          longint e; bit c; string t;
          e = exp_q.pop_front(); c = care_q.pop_front(); t = tag_q.pop_front();
          if (c) begin
            checks++;
            if (longint'(out_dat) != e) begin
              fails++; $display("FAIL %s data mismatch: got %0d expected %0d", t, out_dat, e);
            end
          end
        end
      end
      if (out_sof) begin
        checks++;
        if (sof_q.size() == 0) begin
          fails++; $display("FAIL R4 unexpected out_sof: got 1 expected 0");
        end else begin
          int t0;
          t0 = sof_q.pop_front();
          if (cyc - t0 != LAT) begin
            fails++; $display("FAIL R4 latency: got %0d expected %0d", cyc - t0, LAT);
          end
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++; fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    checks++; // R1 during reset
    if (out_vld !== 1'b0 || out_sof !== 1'b0) begin
      fails++; $display("FAIL R1 in reset: got vld=%b sof=%b expected 0 0", out_vld, out_sof);
    end
    @(posedge clk); #1 rst = 1'b0;
    @(negedge clk);
    checks++; // R1 first cycle after reset
    if (out_vld !== 1'b0 || out_sof !== 1'b0) begin
      fails++; $display("FAIL R1 after reset: got vld=%b sof=%b expected 0 0", out_vld, out_sof);
    end
    send_frame(N, 0, 1'b0, "R2");       // impulse, forward
    send_frame(N, 1, 1'b0, "R6");       // ramp, back to back
    send_frame(N, 4, 1'b0, "R6");       // quadratic pattern, back to back
    idle(LAT + N);                      // R10: hold mode until drained
    send_frame(N, 2, 1'b1, "R3");       // constant, inverse
    send_frame(N, 3, 1'b1, "R9");       // all p-1, inverse
    idle(LAT + N);
    send_frame(N, 3, 1'b0, "R9");       // all p-1, forward
    idle(5);
    send_frame(5, 1, 1'b0, "R7");       // aborted partial frame
    send_frame(N, 4, 1'b0, "R7");       // restart mid-frame
    idle(LAT + 2 * N);
    checks++; // R5: every expected output was produced
    if (exp_q.size() != 0 || sof_q.size() != 0) begin
      fails++; $display("FAIL R5 missing outputs: got %0d pending expected 0", exp_q.size());
    end
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule